// File: doc/BRIEF.md
# Word-Oriented Stream Cipher Keystream Generator

This core turns a 128-bit key and a 128-bit initialization vector into a stream of 32-bit keystream words. Its state has two parts. The first is a sixteen-word feedback shift register whose new word mixes two field-scaled bytes with shifted and tapped words. The second is a finite-state machine with three 32-bit registers that passes its words through two different 32-bit substitution networks.

A single-cycle `init` pulse captures the key and IV into the state and starts a run of initialization rounds, one round per clock. In each round the state-machine output is folded back into the shift register. One priming step follows, and its state-machine output is thrown away. After that the core presents one keystream word at a time with a valid flag, and it moves to the next word on every clock where the consumer asserts `ready`. While the core is loading it raises `busy`. A new `init` pulse restarts the whole process at any time.

Top module: `wsc_keystream_core`

## Requirements
- R1: After reset `ks_valid` and `busy` are 0. `ks_word` reads 0 on every cycle where `ks_valid` is low.
- R2: A rising clock edge that samples `init` high captures `key` and `iv` and clears the three machine registers. In the next cycle `busy` is 1 and `ks_valid` is 0. `key` and `iv` are sampled only on that edge, so changing them later has no effect on the stream.
- R3: Write k_i = key[32i+31:32i] and v_i = iv[32i+31:32i]. Then: cell 0..3 = ~k0, ~k1, ~k2, ~k3; cell 4..7 = k0, k1, k2, k3; cell 8 = ~k0; cell 9 = ~k1^v3; cell 10 = ~k2^v2; cell 11 = ~k3; cell 12 = k0^v1; cell 13 = k1; cell 14 = k2; cell 15 = k3^v0.
- R4: One register step XORs five terms into a new word: C2; C0 shifted left 8; C11 shifted right 8; MA(C0[31:24]); and DA(C11[7:0]). During initialization rounds the machine output F is XORed in as well. Each cell c takes the old cell c+1, and the new word enters cell 15.
- R5: The machine output is F = ((C15 + R1) mod 2^32) XOR R2. One machine step assigns all three registers at once: R3 gets T2(R2), R2 gets T1(R1), and R1 gets R2 + (R3 XOR C5) mod 2^32.
- R6: After the init edge the core runs INIT_ROUNDS rounds (default 32), one per clock. Each round is a machine step followed by a register step with F folded in. Then comes one priming clock: a machine step whose output is discarded, and a register step without F. Count the init edge as edge 1. `ks_valid` rises at edge INIT_ROUNDS+2, and `busy` is high from edge 1 until that same edge.
- R7: While `ks_valid` is high, `ks_word` equals F XOR C0 of the current state. Each edge with `ks_valid` and `ready` both high performs one machine step and one register step without F.
- R8: An edge with `ks_valid` high and `ready` low leaves `ks_word` and `ks_valid` unchanged.
- R9: `init` during streaming restarts loading. It takes priority over `ready`, so no word is advanced on that edge.
- R10: `init` while `busy` is high restarts loading and the round count. Only the newest key and IV determine the stream.
- R11: T1 works on a word whose byte 0 is bits 31:24. Each byte b is first replaced by its inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapped to 0. The result y then becomes y ^ rotl(y,1) ^ rotl(y,2) ^ rotl(y,3) ^ rotl(y,4) ^ 0x63. Output byte i is 2·s_i ^ 3·s_(i-1) ^ s_(i+1) ^ s_(i+2), with indices taken mod 4 and arithmetic in the same field.
- R12: T2 replaces each byte x with x + x^9 + x^13 + x^15 + x^33 + x^41 + x^45 + x^47 + x^49, computed in GF(2^8) modulo x^8+x^6+x^5+x^3+1, and then XORs 0x25. It then mixes the bytes with the same pattern as R11, using arithmetic in that field.
- R13: In GF(2^8) modulo x^8+x^7+x^5+x^3+1, MA(c) is the word with bytes c·x^23, c·x^245, c·x^48 and c·x^239, and DA(c) is the word with bytes c·x^16, c·x^39, c·x^6 and c·x^64. In both words the first byte is the most significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Load key and IV, then start initialization |
| key | input | 128 | Key, word i in bits 32i+31:32i |
| iv | input | 128 | Initialization vector, word i in bits 32i+31:32i |
| ready | input | 1 | Consumer accepts the presented word |
| ks_word | output | 32 | Current keystream word, 0 when not valid |
| ks_valid | output | 1 | Keystream word present |
| busy | output | 1 | Initialization or priming in progress |

## Verification
The bench builds the core with the default INIT_ROUNDS of 32 and the standard 16-cell register. At that size every initialization is only 34 cycles long, so the bench can sweep many keys, IVs and ready patterns. The bench model builds its own S-box tables over all 256 byte values: it finds inverses by brute-force search and evaluates the power sum directly. Those tables feed a word-level software model, which is compared against every presented word, including words that are held. Restarts during streaming and during the initialization rounds are exercised, and so are inputs that change after the init edge.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int KEY_WORDS = 4;
  localparam int ROM_W = 256 * BYTE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_PRIME,
    ST_RUN
  } phase_t;

  // multiply by x in GF(2^8) with the given reduction byte
  function automatic byte_t gf_dbl(input byte_t v, input byte_t red);
    return v[7] ? ({v[6:0], 1'b0} ^ red) : {v[6:0], 1'b0};
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b, input byte_t red);
    byte_t acc;
    byte_t cur;
    acc = '0;
    cur = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ cur;
      cur = gf_dbl(cur, red);
    end
    return acc;
  endfunction

  // v * x^n, n below 256
  function automatic byte_t gf_dbl_n(input byte_t v, input int n, input byte_t red);
    byte_t t;
    t = v;
    for (int i = 0; i < 256; i++) begin
      if (i < n) t = gf_dbl(t, red);
    end
    return t;
  endfunction

  // field inverse (x^254) followed by the affine step
  function automatic byte_t inv_affine_sub(input byte_t x);
    byte_t sq;
    byte_t acc;
    sq  = x;
    acc = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      sq  = gf_mul(sq, sq, 8'h1b);
      acc = gf_mul(acc, sq, 8'h1b);
    end
    return acc ^ {acc[6:0], acc[7]} ^ {acc[5:0], acc[7:6]} ^
           {acc[4:0], acc[7:5]} ^ {acc[3:0], acc[7:4]} ^ 8'h63;
  endfunction

  // odd power sum over the second field, plus constant
  function automatic byte_t dickson_sub(input byte_t x);
    byte_t p;
    byte_t acc;
    p   = 8'h01;
    acc = '0;
    for (int k = 1; k <= 49; k++) begin
      p = gf_mul(p, x, 8'h69);
      if (k == 1 || k == 9 || k == 13 || k == 15 || k == 33 ||
          k == 41 || k == 45 || k == 47 || k == 49)
        acc = acc ^ p;
    end
    return acc ^ 8'h25;
  endfunction

  function automatic logic [ROM_W-1:0] build_sub_rom(input int variant);
    logic [ROM_W-1:0] rom;
    for (int i = 0; i < 256; i++) begin
      rom[i*BYTE_W +: BYTE_W] = (variant == 0) ? inv_affine_sub(byte_t'(i))
                                               : dickson_sub(byte_t'(i));
    end
    return rom;
  endfunction

  // eight basis words of the byte-to-word alpha map (linear over GF(2))
  function automatic logic [8*WORD_W-1:0] alpha_basis(input bit divide);
    logic [8*WORD_W-1:0] tbl;
    int e [4];
    byte_t c;
    if (divide) e = '{16, 39, 6, 64};
    else        e = '{23, 245, 48, 239};
    for (int j = 0; j < BYTE_W; j++) begin
      c = byte_t'(1 << j);
      for (int l = 0; l < 4; l++) begin
        tbl[j*WORD_W + (3-l)*BYTE_W +: BYTE_W] = gf_dbl_n(c, e[l], 8'ha9);
      end
    end
    return tbl;
  endfunction

  function automatic word_t alpha_apply(input logic [8*WORD_W-1:0] basis, input byte_t c);
    word_t acc;
    acc = '0;
    for (int j = 0; j < BYTE_W; j++) begin
      if (c[j]) acc = acc ^ basis[j*WORD_W +: WORD_W];
    end
    return acc;
  endfunction

endpackage

// File: rtl/wsc_sbox_mix.sv
module wsc_sbox_mix
  import wsc_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  word_t din,
  output word_t dout
);

  localparam byte_t MIX_RED = (VARIANT == 0) ? 8'h1b : 8'h69;
  localparam logic [ROM_W-1:0] SUB_ROM = build_sub_rom(VARIANT);
  localparam int LANES = WORD_W / BYTE_W;

  byte_t sub [LANES];

  // lane 0 is the most significant byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sub[g] = SUB_ROM[{din[BYTE_W*(LANES-1-g) +: BYTE_W], 3'b000} +: BYTE_W];
    assign dout[BYTE_W*(LANES-1-g) +: BYTE_W] =
        gf_dbl(sub[g], MIX_RED) ^
        gf_dbl(sub[(g+LANES-1)%LANES], MIX_RED) ^ sub[(g+LANES-1)%LANES] ^
        sub[(g+1)%LANES] ^ sub[(g+2)%LANES];
  end

endmodule

// File: rtl/wsc_fsm.sv
module wsc_fsm
  import wsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  input  word_t tail_word,
  input  word_t mid_word,
  output word_t f_word
);

  word_t r1, r2, r3;
  word_t t1_out, t2_out;

  wsc_sbox_mix #(.VARIANT(0)) u_t1 (.din(r1), .dout(t1_out));
  wsc_sbox_mix #(.VARIANT(1)) u_t2 (.din(r2), .dout(t2_out));

  assign f_word = (tail_word + r1) ^ r2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 <= '0;
      r2 <= '0;
      r3 <= '0;
    end else if (load) begin
      r1 <= '0;
      r2 <= '0;
      r3 <= '0;
    end else if (step) begin
      r1 <= r2 + (r3 ^ mid_word);
      r2 <= t1_out;
      r3 <= t2_out;
    end
  end

  // R5
  fsm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (r1 == '0) && (r2 == '0) && (r3 == '0));

  // R5
  fsm_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(r1) && $stable(r2) && $stable(r3));

endmodule

// File: rtl/wsc_lfsr.sv
module wsc_lfsr
  import wsc_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int NEAR_TAP = 2,
  parameter int MID_TAP  = 5,
  parameter int FAR_TAP  = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic                    fold_in,
  input  logic [DEPTH*WORD_W-1:0] seed,
  input  word_t                   f_in,
  output word_t                   head,
  output word_t                   mid,
  output word_t                   tail
);

  localparam logic [8*WORD_W-1:0] MUL_BASIS = alpha_basis(1'b0);
  localparam logic [8*WORD_W-1:0] DIV_BASIS = alpha_basis(1'b1);

  word_t cells [DEPTH];
  word_t feedback;

  assign feedback = {cells[0][WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}} ^
                    alpha_apply(MUL_BASIS, cells[0][WORD_W-1 -: BYTE_W]) ^
                    cells[NEAR_TAP] ^
                    {{BYTE_W{1'b0}}, cells[FAR_TAP][WORD_W-1:BYTE_W]} ^
                    alpha_apply(DIV_BASIS, cells[FAR_TAP][BYTE_W-1:0]) ^
                    (fold_in ? f_in : '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cells[g] <= '0;
      else if (load)   cells[g] <= seed[g*WORD_W +: WORD_W];
      else if (step) begin
        if (g == DEPTH-1) cells[g] <= feedback;
        else              cells[g] <= cells[(g+1)%DEPTH];
      end
    end
  end

  assign head = cells[0];
  assign mid  = cells[MID_TAP];
  assign tail = cells[DEPTH-1];

  // R4
  shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cells[0] == $past(cells[1])) &&
                        (cells[DEPTH-2] == $past(cells[DEPTH-1])));

endmodule

// File: rtl/wsc_keystream_core.sv
module wsc_keystream_core
  import wsc_pkg::*;
#(
  parameter int INIT_ROUNDS = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic [127:0] key,
  input  logic [127:0] iv,
  input  logic         ready,
  output logic [31:0]  ks_word,
  output logic         ks_valid,
  output logic         busy
);

  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(INIT_ROUNDS + 1);
  localparam logic [CNT_W-1:0] LAST_ROUND = CNT_W'(INIT_ROUNDS - 1);

  phase_t           phase;
  logic [CNT_W-1:0] round_cnt;
  word_t            kw [KEY_WORDS];
  word_t            vw [KEY_WORDS];
  logic [DEPTH*WORD_W-1:0] seed;
  word_t            head, mid, tail, f_word;

  // named internal events
  logic accept, advance, round_last, fold_f;

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_split
    assign kw[g] = key[g*WORD_W +: WORD_W];
    assign vw[g] = iv[g*WORD_W +: WORD_W];
  end

  assign seed = {kw[3] ^ vw[0], kw[2], kw[1], kw[0] ^ vw[1],
                 ~kw[3], ~kw[2] ^ vw[2], ~kw[1] ^ vw[3], ~kw[0],
                 kw[3], kw[2], kw[1], kw[0],
                 ~kw[3], ~kw[2], ~kw[1], ~kw[0]};

  assign ks_valid   = (phase == ST_RUN);
  assign busy       = (phase == ST_INIT) || (phase == ST_PRIME);
  assign accept     = ks_valid && ready;
  assign advance    = !init && (busy || accept);
  assign round_last = (phase == ST_INIT) && (round_cnt == LAST_ROUND);
  assign fold_f     = (phase == ST_INIT);
  assign ks_word    = ks_valid ? (f_word ^ head) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= ST_IDLE;
      round_cnt <= '0;
    end else if (init) begin
      phase     <= ST_INIT;
      round_cnt <= '0;
    end else begin
      case (phase)
        ST_INIT: begin
          if (round_last) phase <= ST_PRIME;
          else            round_cnt <= round_cnt + 1'b1;
        end
        ST_PRIME: phase <= ST_RUN;
        default:  phase <= phase;
      endcase
    end
  end

  wsc_lfsr #(.DEPTH(DEPTH)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (init),
    .step    (advance),
    .fold_in (fold_f),
    .seed    (seed),
    .f_in    (f_word),
    .head    (head),
    .mid     (mid),
    .tail    (tail)
  );

  wsc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (init),
    .step      (advance),
    .tail_word (tail),
    .mid_word  (mid),
    .f_word    (f_word)
  );

  // R2
  init_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> busy && !ks_valid);

  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !ready && !init) |=> ks_valid && $stable(ks_word));

  // R6
  prime_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_PRIME) |-> $past(round_last) && !$past(init));

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ks_valid) |-> $past(phase) == ST_PRIME);

endmodule

// File: tb/wsc_keystream_core_tb.sv
module wsc_keystream_core_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init = 1'b0;
  logic         ready = 1'b0;
  logic [127:0] key = '0;
  logic [127:0] iv = '0;
  logic [31:0]  ks_word;
  logic         ks_valid;
  logic         busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0]  t_sr [256];
  logic [7:0]  t_sq [256];
  logic [31:0] m_s [16];
  logic [31:0] m_r1, m_r2, m_r3;

  always #2 clk = ~clk;

  wsc_keystream_core u_dut (
    .clk(clk), .rst_n(rst_n), .init(init), .key(key), .iv(iv),
    .ready(ready), .ks_word(ks_word), .ks_valid(ks_valid), .busy(busy)
  );

  function automatic logic [7:0] xt(input logic [7:0] v, input logic [7:0] red);
    return {v[6:0], 1'b0} ^ (v[7] ? red : 8'h00);
  endfunction

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b, input logic [7:0] red);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      r = xt(r, red);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [7:0] xt_pow(input logic [7:0] v, input int n);
    logic [7:0] t;
    t = v;
    for (int i = 0; i < n; i++) t = xt(t, 8'ha9);
    return t;
  endfunction

  // R13 alpha maps computed by direct repeated doubling
  function automatic logic [31:0] amul(input logic [7:0] c);
    return {xt_pow(c, 23), xt_pow(c, 245), xt_pow(c, 48), xt_pow(c, 239)};
  endfunction

  function automatic logic [31:0] adiv(input logic [7:0] c);
    return {xt_pow(c, 16), xt_pow(c, 39), xt_pow(c, 6), xt_pow(c, 64)};
  endfunction

  // R11 / R12 word transforms with explicit 2/3 coefficients
  function automatic logic [31:0] tword(input logic [31:0] w, input bit second);
    logic [7:0] s [4];
    logic [7:0] red;
    red = second ? 8'h69 : 8'h1b;
    for (int i = 0; i < 4; i++)
      s[i] = second ? t_sq[w[31-8*i -: 8]] : t_sr[w[31-8*i -: 8]];
    return {fmul(s[0], 8'd2, red) ^ s[1] ^ s[2] ^ fmul(s[3], 8'd3, red),
            fmul(s[0], 8'd3, red) ^ fmul(s[1], 8'd2, red) ^ s[2] ^ s[3],
            s[0] ^ fmul(s[1], 8'd3, red) ^ fmul(s[2], 8'd2, red) ^ s[3],
            s[0] ^ s[1] ^ fmul(s[2], 8'd3, red) ^ fmul(s[3], 8'd2, red)};
  endfunction

  task automatic build_tables();
    logic [7:0] inv, b, pw, acc;
    for (int x = 0; x < 256; x++) begin
      inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (fmul(8'(x), 8'(y), 8'h1b) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        b[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
      t_sr[x] = b ^ 8'h63;
      pw = 8'h01;
      acc = 8'h00;
      for (int k = 1; k <= 49; k++) begin
        pw = fmul(pw, 8'(x), 8'h69);
        if (k inside {1, 9, 13, 15, 33, 41, 45, 47, 49}) acc = acc ^ pw;
      end
      t_sq[x] = acc ^ 8'h25;
    end
  endtask

  // R3 load layout
  task automatic m_load(input logic [127:0] k, input logic [127:0] v);
    logic [31:0] kk [4];
    logic [31:0] vv [4];
    for (int i = 0; i < 4; i++) begin
      kk[i] = k[32*i +: 32];
      vv[i] = v[32*i +: 32];
    end
    for (int i = 0; i < 4; i++) begin
      m_s[i]     = ~kk[i];
      m_s[i + 4] = kk[i];
    end
    m_s[8]  = ~kk[0];
    m_s[9]  = ~kk[1] ^ vv[3];
    m_s[10] = ~kk[2] ^ vv[2];
    m_s[11] = ~kk[3];
    m_s[12] = kk[0] ^ vv[1];
    m_s[13] = kk[1];
    m_s[14] = kk[2];
    m_s[15] = kk[3] ^ vv[0];
    m_r1 = '0;
    m_r2 = '0;
    m_r3 = '0;
  endtask

  // R5
  task automatic m_fsm(output logic [31:0] f);
    logic [31:0] n1;
    f = (m_s[15] + m_r1) ^ m_r2;
    n1 = m_r2 + (m_r3 ^ m_s[5]);
    m_r3 = tword(m_r2, 1'b1);
    m_r2 = tword(m_r1, 1'b0);
    m_r1 = n1;
  endtask

  // R4
  task automatic m_lfsr(input bit with_f, input logic [31:0] f);
    logic [31:0] nw;
    nw = (m_s[0] << 8) ^ amul(m_s[0][31:24]) ^ m_s[2] ^ (m_s[11] >> 8) ^
         adiv(m_s[11][7:0]) ^ (with_f ? f : 32'h0);
    for (int i = 0; i < 15; i++) m_s[i] = m_s[i+1];
    m_s[15] = nw;
  endtask

  task automatic m_step(input bit with_f);
    logic [31:0] f;
    m_fsm(f);
    m_lfsr(with_f, f);
  endtask

  function automatic logic [31:0] m_z();
    return ((m_s[15] + m_r1) ^ m_r2) ^ m_s[0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // entered at a negedge; leaves at the negedge where valid first shows
  task automatic start_run(input logic [127:0] k, input logic [127:0] v,
                           input bit rdy, input string tag);
    key = k;
    iv = v;
    init = 1'b1;
    ready = rdy;
    @(negedge clk);
    init = 1'b0;
    ready = 1'b0;
    key = ~k ^ 128'h5a5a;   // R2: later key/iv changes must not matter
    iv = {v[63:0], v[127:64]};
    chk(busy && !ks_valid, "R2", {30'd0, busy, ks_valid}, 32'h2);
    chk(ks_word == 32'h0, "R1", ks_word, 32'h0);
    for (int n = 2; n <= 33; n++) @(negedge clk);
    chk(busy && !ks_valid && ks_word == 32'h0, "R6", {30'd0, busy, ks_valid}, 32'h2);
    @(negedge clk);
    chk(!busy && ks_valid, tag, {30'd0, busy, ks_valid}, 32'h1);
    m_load(k, v);
    for (int r = 0; r < 32; r++) m_step(1'b1);
    m_step(1'b0);
  endtask

  task automatic stream(input int nw, input int seed);
    int got;
    bit rdy;
    bit prev_rdy;
    logic [31:0] exp;
    got = 0;
    prev_rdy = 1'b1;
    for (int cyc = 0; got < nw; cyc++) begin
      exp = m_z();
      chk(ks_valid && ks_word == exp, prev_rdy ? "R7" : "R8", ks_word, exp);
      rdy = ((cyc * 5 + seed) % 4) != 0;
      ready = rdy;
      @(posedge clk);
      if (rdy) begin
        m_step(1'b0);
        got++;
      end
      prev_rdy = rdy;
      @(negedge clk);
    end
    ready = 1'b0;
  endtask

  function automatic logic [127:0] key_of(input int v);
    if (v == 0) return '0;
    if (v == 1) return '1;
    return {32'h9e3779b9 * v, 32'h7f4a7c15 ^ v, 32'h01234567 + v * 3, 32'hdeadbeef * (v + 1)};
  endfunction

  function automatic logic [127:0] iv_of(input int v);
    if (v == 0) return '0;
    if (v == 1) return {32'h0, 32'hffffffff, 32'h0, 32'hffffffff};
    return {32'h13579bdf + v, 32'h2468ace0 * v, 32'hc0ffee00 ^ v, 32'h8badf00d + 7 * v};
  endfunction

  initial begin
    build_tables();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!ks_valid && !busy, "R1", {30'd0, busy, ks_valid}, 32'h0);
    chk(ks_word == 32'h0, "R1", ks_word, 32'h0);

    // R3 R11 R12 R13 through many key/IV pairs
    for (int v = 0; v < 6; v++) begin
      start_run(key_of(v), iv_of(v), 1'b0, "R6");
      stream(24, v);
    end

    // R9 restart while streaming, with ready high on the init edge
    start_run(key_of(7), iv_of(7), 1'b0, "R6");
    stream(5, 1);
    ready = 1'b1;
    start_run(key_of(8), iv_of(8), 1'b1, "R9");
    stream(12, 2);

    // R10 restart during the initialization rounds
    key = key_of(9);
    iv = iv_of(9);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy && !ks_valid, "R10", {30'd0, busy, ks_valid}, 32'h2);
    start_run(key_of(10), iv_of(10), 1'b0, "R10");
    stream(16, 3);

    summary();
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual timeout expected completion");
      summary();
    end
  end

endmodule